// File: doc/BRIEF.md
# Sector Burst FIFO Transfer Engine

This engine moves 128-bit words between a user-side FIFO and an internal data buffer in bursts of 32 words (512 bytes, one sector). A transfer is started by a one-cycle `start` pulse that loads a sector count and picks a direction. In the transmit direction the engine reads words out of the user transmit FIFO and passes them to the buffer. In the receive direction it pops words from the buffer and writes them into the user receive FIFO. It runs one burst per sector. After the last sector it gives a one-cycle `done` pulse, and `busy` falls in the cycle after that.

A burst starts only when the FIFO occupancy inputs show room for a whole burst. For transmit, the read count must show at least 32 stored words. For receive, the write count must not have all of its bits from 6 upwards set, and the buffer must already hold 32 words. FIFOs whose counters are narrower than 16 bits pad the upper bits: the write count is padded with ones and the read count with zeros. Read data from the transmit FIFO arrives one cycle after the read enable. The buffer is show-ahead: its head word sits on `buf_rd_data`, and it advances on every cycle in which `rx_wr_en` is high.

The controller is a state machine with these states:
- ST_IDLE: waits for `start`. A zero length goes to ST_FINISH, direction 0 goes to ST_TX_WAIT and direction 1 goes to ST_RX_WAIT.
- ST_TX_WAIT: moves to ST_TX_BURST when the transmit gate opens.
- ST_TX_BURST: runs 32 read cycles, then goes to ST_FINISH after the last sector or back to ST_TX_WAIT otherwise.
- ST_RX_WAIT: moves to ST_RX_BURST when the receive gate opens.
- ST_RX_BURST: runs 32 write cycles, then goes to ST_FINISH after the last sector or to ST_RX_GAP otherwise.
- ST_RX_GAP: holds for one idle cycle, then goes to ST_RX_WAIT.
- ST_FINISH: pulses `done`, then goes to ST_IDLE.

Top module: `sector_burst_engine`

## Requirements
- R1: While reset is held, `busy`, `done`, `tx_rd_en`, `rx_wr_en` and `buf_wr_en` are all low.
- R2: A transmit burst begins only in the cycle after one in which `tx_rd_cnt[15:5]` was nonzero (at least 32 words stored). A count of 31 never starts one, and a count of 16'h8000 does.
- R3: Each transmit burst holds `tx_rd_en` high for exactly 32 consecutive cycles.
- R4: `buf_wr_en` is high exactly one cycle after each `tx_rd_en` cycle, and in that cycle `buf_wr_data` equals `tx_rd_data`.
- R5: A receive burst begins only in the cycle after one in which `rx_wr_cnt[15:6]` was not all ones and `buf_words` was at least 32. With 16'hFFC0 or with `buf_words`=31 it waits, and with 16'hFFBF and 32 words it runs.
- R6: Each receive burst holds `rx_wr_en` high for exactly 32 cycles and is followed by at least one low cycle. While `rx_wr_en` is high, `rx_wr_data` equals `buf_rd_data`.
- R7: The engine runs exactly `total_sectors` bursts. `done` is high for one cycle, in the cycle after the last enable cycle of the final burst. A length of 0 gives `done` in the cycle after `start` with no burst.
- R8: `start` is ignored while `busy` is high. The loaded length and direction are not changed.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle, and low in the cycle after `done`.
- R10: Direction 0 (`dir_rx`=0) never raises `rx_wr_en`, and direction 1 never raises `tx_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that loads the length and direction while the engine is idle |
| dir_rx | input | 1 | Direction select: 0 transmit (FIFO to buffer), 1 receive (buffer to FIFO) |
| total_sectors | input | 32 | Number of 512-byte sectors to transfer |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle completion strobe |
| tx_rd_cnt | input | 16 | Word count of the transmit FIFO, upper bits padded with zeros |
| tx_rd_en | output | 1 | Transmit FIFO read enable |
| tx_rd_data | input | 128 | Transmit FIFO read data, valid the cycle after `tx_rd_en` |
| buf_wr_en | output | 1 | Buffer write strobe for transmit data |
| buf_wr_data | output | 128 | Word written to the buffer |
| buf_words | input | 16 | Words waiting in the internal buffer |
| buf_rd_data | input | 128 | Head word of the internal buffer (show-ahead) |
| rx_wr_cnt | input | 16 | Word count of the receive FIFO, upper bits padded with ones |
| rx_wr_en | output | 1 | Receive FIFO write enable, also pops the buffer |
| rx_wr_data | output | 128 | Word written to the receive FIFO |

## Verification
A wrong beat count shows up at once as an enable run that is one cycle short or long. A wrong sector counter shows up as an extra or missing burst and as a `done` pulse in the wrong cycle, visible at the end of the transfer. A stuck state shows up as an enable that stays low once the gate has opened, or as a missing receive gap cycle, within one cycle of the event. The reference model in the bench predicts every output on every clock, so any of these is reported in the first cycle it departs from the requirements.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_WAIT,
        ST_TX_BURST,
        ST_RX_WAIT,
        ST_RX_BURST,
        ST_RX_GAP,
        ST_FINISH
    } sbe_state_e;
endpackage

// File: rtl/sbe_gate.sv
module sbe_gate #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned BUFCNT_W    = 16,
    parameter int unsigned BURST_WORDS = 32
) (
    input  logic [CNT_W-1:0]    tx_cnt,
    input  logic [CNT_W-1:0]    rx_cnt,
    input  logic [BUFCNT_W-1:0] buf_words,
    output logic                tx_ok,
    output logic                rx_ok
);
    // transmit: a whole burst stored; receive: count below all-ones in the upper slice
    localparam logic [CNT_W-1:0] TX_MIN   = CNT_W'(BURST_WORDS);
    localparam logic [CNT_W-1:0] RX_LIMIT = ~CNT_W'((2 * BURST_WORDS) - 1);

    always_comb begin
        tx_ok = (tx_cnt >= TX_MIN);
        rx_ok = (rx_cnt < RX_LIMIT) && (buf_words >= BUFCNT_W'(BURST_WORDS));
    end
endmodule

// File: rtl/sbe_beat_ctr.sv
module sbe_beat_ctr #(
    parameter int unsigned BURST_WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int unsigned BEAT_W = $clog2(BURST_WORDS);
    localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(BURST_WORDS - 1);

    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (run) begin
            beat_q <= (beat_q == BEAT_END) ? '0 : beat_q + 1'b1;
        end
    end

    assign last = run && (beat_q == BEAT_END);
endmodule

// File: rtl/sbe_sector_ctr.sv
module sbe_sector_ctr #(
    parameter int unsigned LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             on_last
);
    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign on_last = (remain_q == LEN_W'(1));
endmodule

// File: rtl/sector_burst_engine.sv
module sector_burst_engine #(
    parameter int unsigned DATA_W      = 128,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned BUFCNT_W    = 16,
    parameter int unsigned LEN_W       = 32,
    parameter int unsigned BURST_WORDS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                dir_rx,
    input  logic [LEN_W-1:0]    total_sectors,
    output logic                busy,
    output logic                done,
    input  logic [CNT_W-1:0]    tx_rd_cnt,
    output logic                tx_rd_en,
    input  logic [DATA_W-1:0]   tx_rd_data,
    output logic                buf_wr_en,
    output logic [DATA_W-1:0]   buf_wr_data,
    input  logic [BUFCNT_W-1:0] buf_words,
    input  logic [DATA_W-1:0]   buf_rd_data,
    input  logic [CNT_W-1:0]    rx_wr_cnt,
    output logic                rx_wr_en,
    output logic [DATA_W-1:0]   rx_wr_data
);
    import sbe_pkg::*;

    localparam int unsigned RUN_W  = $clog2(BURST_WORDS) + 1;
    localparam int unsigned TX_LSB = $clog2(BURST_WORDS);
    localparam int unsigned RX_LSB = TX_LSB + 1;

    sbe_state_e state_q, state_d;
    logic tx_ok, rx_ok, beat_last, sec_last, run, load;

    assign run  = (state_q == ST_TX_BURST) || (state_q == ST_RX_BURST);
    assign load = (state_q == ST_IDLE) && start;

    sbe_gate #(.CNT_W(CNT_W), .BUFCNT_W(BUFCNT_W), .BURST_WORDS(BURST_WORDS)) u_gate (
        .tx_cnt(tx_rd_cnt), .rx_cnt(rx_wr_cnt), .buf_words(buf_words),
        .tx_ok(tx_ok), .rx_ok(rx_ok)
    );

    sbe_beat_ctr #(.BURST_WORDS(BURST_WORDS)) u_beat (
        .clk(clk), .rst_n(rst_n), .run(run), .last(beat_last)
    );

    sbe_sector_ctr #(.LEN_W(LEN_W)) u_sector (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(total_sectors),
        .dec(beat_last), .on_last(sec_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (total_sectors == '0) state_d = ST_FINISH;
                    else if (dir_rx)         state_d = ST_RX_WAIT;
                    else                     state_d = ST_TX_WAIT;
                end
            end
            ST_TX_WAIT:  if (tx_ok) state_d = ST_TX_BURST;
            ST_TX_BURST: if (beat_last) state_d = sec_last ? ST_FINISH : ST_TX_WAIT;
            ST_RX_WAIT:  if (rx_ok) state_d = ST_RX_BURST;
            ST_RX_BURST: if (beat_last) state_d = sec_last ? ST_FINISH : ST_RX_GAP;
            ST_RX_GAP:   state_d = ST_RX_WAIT;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_rd_en   = (state_q == ST_TX_BURST);
        rx_wr_en   = (state_q == ST_RX_BURST);
        done       = (state_q == ST_FINISH);
        busy       = (state_q != ST_IDLE);
        rx_wr_data = buf_rd_data;
        buf_wr_data = tx_rd_data;
    end

    // read data lands one cycle after the enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_wr_en <= 1'b0;
        end else begin
            buf_wr_en <= tx_rd_en;
        end
    end

    // run-length monitors for the burst checks
    logic [RUN_W-1:0] chk_tx_run, chk_rx_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_tx_run <= '0;
            chk_rx_run <= '0;
        end else begin
            chk_tx_run <= tx_rd_en ? chk_tx_run + 1'b1 : '0;
            chk_rx_run <= rx_wr_en ? chk_rx_run + 1'b1 : '0;
        end
    end

    assert_tx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rd_en) |-> ($past(tx_rd_cnt[CNT_W-1:TX_LSB]) != '0));
    assert_tx_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_rd_en) |-> (chk_tx_run == RUN_W'(BURST_WORDS)));
    assert_tx_nolong_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd_en |-> (chk_tx_run < RUN_W'(BURST_WORDS)));
    assert_rx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_wr_en) |-> (!(&$past(rx_wr_cnt[CNT_W-1:RX_LSB])) &&
                             ($past(buf_words) >= BUFCNT_W'(BURST_WORDS))));
    assert_rx_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_wr_en) |-> (chk_rx_run == RUN_W'(BURST_WORDS)));
    assert_rx_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_wr_en) |=> !rx_wr_en);
    assert_done_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_rd_en && rx_wr_en));
endmodule

// File: tb/sector_burst_engine_bench.sv
module sector_burst_engine_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0, start = 1'b0, dir_rx = 1'b0;
    logic [31:0]  total_sectors = '0;
    logic [15:0]  tx_rd_cnt = '0, rx_wr_cnt = 16'hFFFF, buf_words = '0;
    logic [127:0] tx_rd_data = '0, buf_rd_data = '0;
    logic busy, done, tx_rd_en, buf_wr_en, rx_wr_en;
    logic [127:0] buf_wr_data, rx_wr_data;

    sector_burst_engine u_sector_burst_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx),
        .total_sectors(total_sectors), .busy(busy), .done(done),
        .tx_rd_cnt(tx_rd_cnt), .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .buf_words(buf_words),
        .buf_rd_data(buf_rd_data), .rx_wr_cnt(rx_wr_cnt), .rx_wr_en(rx_wr_en),
        .rx_wr_data(rx_wr_data)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    bit compare_on = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] pat_tx(input int i);
        return {32'(i + 3), ~32'(i), 32'(i * 7), 32'hA5A50000 | 32'(i)};
    endfunction
    function automatic logic [127:0] pat_rx(input int i);
        return {32'h5A5A0000 | 32'(i), 32'(i * 11), ~32'(i + 1), 32'(i)};
    endfunction

    // behavioural reference
    bit m_active, m_fin, m_dir, m_inburst, m_gap, m_bwe;
    int m_beats, m_sectors;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_fin = 0; m_inburst = 0; m_gap = 0; m_bwe = 0;
        end else begin
            m_bwe = m_active && !m_dir && m_inburst;
            if (m_fin) m_fin = 0;
            else if (!m_active) begin
                if (start) begin
                    if (total_sectors == 0) m_fin = 1;
                    else begin
                        m_active = 1; m_dir = dir_rx; m_sectors = total_sectors;
                        m_inburst = 0; m_gap = 0;
                    end
                end
            end else if (m_inburst) begin
                m_beats--;
                if (m_beats == 0) begin
                    m_inburst = 0;
                    m_sectors--;
                    if (m_sectors == 0) begin m_active = 0; m_fin = 1; end
                    else if (m_dir) m_gap = 1;
                end
            end else if (m_gap) m_gap = 0;
            else if (!m_dir ? (tx_rd_cnt >= 32) : (rx_wr_cnt < 16'hFFC0 && buf_words >= 32)) begin
                m_inburst = 1; m_beats = 32;
            end
        end
    end

    // fifo / buffer sources
    bit rd_seen, wr_seen;
    int tx_src = 0, rx_src = 0, tx_chk = 0, rx_chk = 0;
    int tx_en_cyc = 0, rx_en_cyc = 0, done_cnt = 0;

    always @(posedge clk) begin
        #1;
        if (rd_seen) begin tx_rd_data = pat_tx(tx_src); tx_src++; end
        if (wr_seen) begin rx_src++; buf_rd_data = pat_rx(rx_src); end
    end

    always @(negedge clk) begin
        rd_seen = tx_rd_en;
        wr_seen = rx_wr_en;
        if (compare_on) begin
            if (tx_rd_en) tx_en_cyc++;
            if (rx_wr_en) rx_en_cyc++;
            if (done) done_cnt++;
            chk("R9 busy", busy, m_active || m_fin);
            chk("R7 done", done, m_fin);
            chk("R3 tx_rd_en", tx_rd_en, m_active && !m_dir && m_inburst);
            chk("R6 rx_wr_en", rx_wr_en, m_active && m_dir && m_inburst);
            chk("R4 buf_wr_en", buf_wr_en, m_bwe);
            if (buf_wr_en) begin
                chk("R4 buf_wr_data", buf_wr_data, pat_tx(tx_chk));
                tx_chk++;
            end
            if (rx_wr_en) begin
                chk("R6 rx_wr_data", rx_wr_data, pat_rx(rx_chk));
                rx_chk++;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic kick(input bit d, input int len);
        dir_rx = d; total_sectors = 32'(len); start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic clear_counts();
        tx_en_cyc = 0; rx_en_cyc = 0; done_cnt = 0;
    endtask

    initial begin
        buf_rd_data = pat_rx(0);
        step(3);
        @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 done in reset", done, 1'b0);
        chk("R1 tx_rd_en in reset", tx_rd_en, 1'b0);
        chk("R1 rx_wr_en in reset", rx_wr_en, 1'b0);
        chk("R1 buf_wr_en in reset", buf_wr_en, 1'b0);
        step(1);
        rst_n = 1'b1;
        compare_on = 1;
        step(2);

        // transmit, 3 sectors, first held back by a 31-word count
        clear_counts();
        tx_rd_cnt = 16'h001F;
        kick(1'b0, 3);
        step(20);
        chk("R2 no tx burst below 32 words", 32'(tx_en_cyc), 32'd0);
        tx_rd_cnt = 16'h0020;
        step(130);
        chk("R7 tx enable cycles for 3 sectors", 32'(tx_en_cyc), 32'd96);
        chk("R10 no rx write in transmit", 32'(rx_en_cyc), 32'd0);
        chk("R7 single done tx", 32'(done_cnt), 32'd1);
        tx_rd_cnt = 16'h0000;

        // receive, 2 sectors, gated by count then by buffer level
        clear_counts();
        rx_wr_cnt = 16'hFFC0; buf_words = 16'd100;
        kick(1'b1, 2);
        step(20);
        chk("R5 no rx burst with upper count all ones", 32'(rx_en_cyc), 32'd0);
        rx_wr_cnt = 16'hFFBF; buf_words = 16'd31;
        step(20);
        chk("R5 no rx burst with 31 buffered", 32'(rx_en_cyc), 32'd0);
        buf_words = 16'd32;
        step(10);
        dir_rx = 1'b0; total_sectors = 32'd7; start = 1'b1;  // R8 ignored
        step(1);
        start = 1'b0;
        step(120);
        chk("R8 rx length unchanged by busy start", 32'(rx_en_cyc), 32'd64);
        chk("R10 no tx read in receive", 32'(tx_en_cyc), 32'd0);
        chk("R7 single done rx", 32'(done_cnt), 32'd1);
        rx_wr_cnt = 16'hFFFF; buf_words = 16'd0;

        // zero length
        clear_counts();
        kick(1'b0, 0);
        step(10);
        chk("R7 zero length done", 32'(done_cnt), 32'd1);
        chk("R7 zero length no burst", 32'(tx_en_cyc + rx_en_cyc), 32'd0);

        // transmit boundary: top count bit only
        clear_counts();
        tx_rd_cnt = 16'h8000;
        kick(1'b0, 1);
        step(50);
        chk("R2 tx runs on count 16'h8000", 32'(tx_en_cyc), 32'd32);
        chk("R7 done after one sector", 32'(done_cnt), 32'd1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule